// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address by walking a four-level radix page table held in memory. A requester supplies the frame number of the top table, the virtual address, whether the access is a store, and whether no-execute is enabled. The walker reads one 64-bit entry per level over a simple request/response memory port. It returns the physical address, the page size and the permissions accumulated along the path, or a fault code, with a one-cycle `done` pulse.

Pages of 4 KiB, 2 MiB and 1 GiB are supported. The walker keeps the accessed and dirty bits up to date with 32-bit compare-and-swap writes on the same port. A failed swap on a table pointer re-reads only that entry. A failed swap on the final mapping restarts the walk from the top table.

Tables are named by the address bits that index them. The top table uses bits 47:39, the second bits 38:30, the third bits 29:21 and the last bits 20:12.

Top module: `ptWalker`

## Requirements
- R1: If bits 63:47 of the virtual address are not all equal, the walk ends at once with fault code 3 (general protection) and issues no memory request.
- R2: Each entry is read at the previous entry's frame base (entry bits 51:12, or the root frame for the top table) plus the 9-bit table index times 8.
- R3: An entry whose bit 0 (present) is clear ends the walk with fault code 1 (not present).
- R4: Fault code 2 (reserved) is raised in any of these cases: entry bits 51 down to the implemented physical width are not zero; bit 63 is set while no-execute is disabled; bit 7 is set in a top-table entry.
- R5: Bit 7 set in a second-table entry gives a 1 GiB page. Bit 7 set in a third-table entry gives a 2 MiB page. A last-table entry always gives a 4 KiB page.
- R6: In a large-page entry, frame bits below the page size must be zero, except bit 12. Any other of these bits set raises fault code 2.
- R7: For a table-pointer entry whose bit 5 (accessed) is clear, the walker writes the entry's low word with bit 5 set, using a compare-and-swap. If the swap fails, only that entry is read again and re-checked.
- R8: At the final mapping, bit 5 is always set, and bit 6 (dirty) is also set for a store. No write is made when these bits are already set. A failed swap restarts the walk from the top table.
- R9: The user, write and execute permissions are the AND, over every entry on the path, of bit 2, bit 1 and the inverse of bit 63 (bit 63 counts only with no-execute enabled).
- R10: On success, `paddr` is the final frame base with its low page bits replaced by the virtual address offset. `pageSize` is 0 for 4 KiB, 1 for 2 MiB and 2 for 1 GiB, and `faultKind` is 0.
- R11: Only one walk runs at a time. A request that arrives while a walk is in progress is ignored. Each walk ends with `done` high for exactly one cycle, and each memory request is a single-cycle strobe.
- R12: After reset, `done` and `memReqValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk (sampled only when idle) |
| reqVaddr | input | 64 | Virtual address |
| reqStore | input | 1 | Access is a store |
| reqRootFrame | input | 40 | Frame number of the top table |
| reqNxEn | input | 1 | No-execute enabled |
| memReqValid | output | 1 | One-cycle memory request strobe |
| memReqWrite | output | 1 | 1 = compare-and-swap of low word, 0 = 64-bit read |
| memReqAddr | output | 52 | Entry address |
| memCmpData | output | 32 | Expected low word for the swap |
| memWrData | output | 32 | New low word for the swap |
| memRespValid | input | 1 | Response strobe |
| memRespData | input | 64 | Read data |
| memCasOk | input | 1 | Swap took place (valid with the response to a write) |
| done | output | 1 | Walk finished, one cycle |
| fault | output | 1 | Walk ended with a fault |
| faultKind | output | 2 | 0 none, 1 not present, 2 reserved, 3 general protection |
| paddr | output | 52 | Translated physical address |
| pageSize | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| permUser | output | 1 | User access allowed on all levels |
| permWrite | output | 1 | Write allowed on all levels |
| permExec | output | 1 | Execute allowed on all levels |

## Verification
The hardest case to reach from the ports is a compare-and-swap that loses to another agent. The walker only writes when a bit is missing, and a well-behaved memory would accept the swap. The bench memory model therefore has a one-shot failure that it arms before a walk. When the armed swap arrives, the model rejects it and sets the bit itself, as a competing agent would. The bench then counts the reads and swaps of that walk. A failed swap on a pointer must cost exactly one extra read. A failed swap on the final mapping must cost a second full set of four reads and then a successful swap.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    FK_NONE   = 2'd0,
    FK_ABSENT = 2'd1,
    FK_RSVD   = 2'd2,
    FK_GP     = 2'd3
  } faultKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadReq;
    logic       latchEntry;
    logic       descend;
    logic       restart;
    logic       finish;
    faultKind_e kind;
  } walkCtl_t;

  // decoded state of the current entry, back to control
  typedef struct packed {
    logic present;
    logic rsvdHit;
    logic leaf;
    logic needCas;
    logic canonical;
  } walkStat_t;

  localparam int P_BIT  = 0;
  localparam int RW_BIT = 1;
  localparam int US_BIT = 2;
  localparam int A_BIT  = 5;
  localparam int D_BIT  = 6;
  localparam int PS_BIT = 7;
  localparam int NX_BIT = 63;
endpackage

// File: rtl/ptwDatapath.sv
module ptwDatapath
  import ptw_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int LEVELS     = 4,
  parameter int IDX_W      = 9,
  parameter int PAGE_SHIFT = 12,
  parameter int PA_W       = 52,
  parameter int PHYS_BITS  = 40,
  localparam int FRAME_W   = PA_W - PAGE_SHIFT,
  localparam int LVL_W     = $clog2(LEVELS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkCtl_t           ctl,
  output walkStat_t          stat,
  input  logic [63:0]        reqVaddr,
  input  logic               reqStore,
  input  logic [FRAME_W-1:0] reqRootFrame,
  input  logic               reqNxEn,
  input  logic [63:0]        memRespData,
  output logic [PA_W-1:0]    memAddr,
  output logic [31:0]        casCmp,
  output logic [31:0]        casNew,
  output logic               outFault,
  output logic [1:0]         outKind,
  output logic [PA_W-1:0]    outPaddr,
  output logic [LVL_W-1:0]   outSize,
  output logic [2:0]         outPerm
);
  localparam int TOP = LEVELS - 1;
  localparam int ENT_SH = PAGE_SHIFT - IDX_W;

  logic [VA_W-1:0]    vaReg;
  logic               storeReg, nxReg;
  logic [FRAME_W-1:0] rootReg, tableBase;
  logic [LVL_W-1:0]   level;
  logic [PA_W-1:0]    entryLo;
  logic               entryNx;
  logic               accU, accW, accX;

  logic unusedRespBits;
  assign unusedRespBits = ^memRespData[62:PA_W];

  // per-level table index and large-page low-bit check
  logic [IDX_W-1:0] idxArr [LEVELS];
  logic             lowRsvd [LEVELS];
  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_lvl
      assign idxArr[g] = vaReg[PAGE_SHIFT + IDX_W*g +: IDX_W];
      if (g == 0 || g == TOP) begin : g_noLarge
        assign lowRsvd[g] = 1'b0;
      end else begin : g_large
        assign lowRsvd[g] = |entryLo[PAGE_SHIFT + IDX_W*g - 1 : PAGE_SHIFT + 1];
      end
    end
    if (PHYS_BITS < PA_W) begin : g_hiRsvd
      logic hiRsvd;
      assign hiRsvd = |entryLo[PA_W-1:PHYS_BITS];
    end else begin : g_hiRsvd
      logic hiRsvd;
      assign hiRsvd = 1'b0;
    end
  endgenerate

  logic isTop, isLast, largeHere, leaf, nxEff;
  logic [31:0] setMask;
  logic [PA_W-1:0] offMask, vaExt, frameAddr;
  int shift;

  always_comb begin
    isTop     = (level == LVL_W'(TOP));
    isLast    = (level == '0);
    largeHere = entryLo[PS_BIT] && !isTop && !isLast;
    leaf      = isLast || largeHere;
    nxEff     = nxReg && entryNx;
    setMask   = 32'(1) << A_BIT;
    if (leaf && storeReg) setMask = setMask | (32'(1) << D_BIT);

    stat.present   = entryLo[P_BIT];
    stat.rsvdHit   = g_hiRsvd.hiRsvd || (!nxReg && entryNx) ||
                     (isTop && entryLo[PS_BIT]) ||
                     (largeHere && lowRsvd[level]);
    stat.leaf      = leaf;
    stat.needCas   = |(setMask & ~entryLo[31:0]);
    stat.canonical = (&reqVaddr[63:VA_W-1]) || !(|reqVaddr[63:VA_W-1]);

    memAddr = PA_W'({tableBase, idxArr[level], ENT_SH'(0)});
    casCmp  = entryLo[31:0];
    casNew  = entryLo[31:0] | setMask;

    shift     = PAGE_SHIFT + IDX_W * int'(level);
    offMask   = (PA_W'(1) << shift) - PA_W'(1);
    vaExt     = PA_W'(vaReg);
    frameAddr = {entryLo[PA_W-1:PAGE_SHIFT], PAGE_SHIFT'(0)};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg     <= '0;
      storeReg  <= 1'b0;
      nxReg     <= 1'b0;
      rootReg   <= '0;
      tableBase <= '0;
      level     <= '0;
      entryLo   <= '0;
      entryNx   <= 1'b0;
      accU      <= 1'b0;
      accW      <= 1'b0;
      accX      <= 1'b0;
      outFault  <= 1'b0;
      outKind   <= '0;
      outPaddr  <= '0;
      outSize   <= '0;
      outPerm   <= '0;
    end else begin
      if (ctl.loadReq) begin
        vaReg     <= reqVaddr[VA_W-1:0];
        storeReg  <= reqStore;
        nxReg     <= reqNxEn;
        rootReg   <= reqRootFrame;
        tableBase <= reqRootFrame;
        level     <= LVL_W'(TOP);
        accU      <= 1'b1;
        accW      <= 1'b1;
        accX      <= 1'b1;
      end
      if (ctl.restart) begin
        tableBase <= rootReg;
        level     <= LVL_W'(TOP);
        accU      <= 1'b1;
        accW      <= 1'b1;
        accX      <= 1'b1;
      end
      if (ctl.latchEntry) begin
        entryLo <= memRespData[PA_W-1:0];
        entryNx <= memRespData[NX_BIT];
      end
      if (ctl.descend) begin
        tableBase <= entryLo[PA_W-1:PAGE_SHIFT];
        level     <= level - LVL_W'(1);
        accU      <= accU & entryLo[US_BIT];
        accW      <= accW & entryLo[RW_BIT];
        accX      <= accX & ~nxEff;
      end
      if (ctl.finish) begin
        outFault <= (ctl.kind != FK_NONE);
        outKind  <= ctl.kind;
        if (ctl.kind == FK_NONE) begin
          outPaddr <= (frameAddr & ~offMask) | (vaExt & offMask);
          outSize  <= level;
          outPerm  <= {accU & entryLo[US_BIT], accW & entryLo[RW_BIT], accX & ~nxEff};
        end else begin
          outPaddr <= '0;
          outSize  <= '0;
          outPerm  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/ptwControl.sv
module ptwControl
  import ptw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  walkStat_t stat,
  input  logic      memRespValid,
  input  logic      memCasOk,
  output walkCtl_t  ctl,
  output logic      memReqValid,
  output logic      memReqWrite,
  output logic      done
);
  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_RD_WAIT, S_EVAL, S_CAS, S_CAS_WAIT, S_FIN
  } walkState_e;

  walkState_e state, nextState;

  always_comb begin
    nextState   = state;
    ctl         = '0;
    ctl.kind    = FK_NONE;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    done        = (state == S_FIN);
    unique case (state)
      S_IDLE: if (reqValid) begin
        if (stat.canonical) begin
          ctl.loadReq = 1'b1;
          nextState   = S_RD;
        end else begin
          ctl.finish = 1'b1;
          ctl.kind   = FK_GP;
          nextState  = S_FIN;
        end
      end
      S_RD: begin
        memReqValid = 1'b1;
        nextState   = S_RD_WAIT;
      end
      S_RD_WAIT: if (memRespValid) begin
        ctl.latchEntry = 1'b1;
        nextState      = S_EVAL;
      end
      S_EVAL: begin
        if (!stat.present) begin
          ctl.finish = 1'b1;
          ctl.kind   = FK_ABSENT;
          nextState  = S_FIN;
        end else if (stat.rsvdHit) begin
          ctl.finish = 1'b1;
          ctl.kind   = FK_RSVD;
          nextState  = S_FIN;
        end else if (stat.needCas) begin
          nextState = S_CAS;
        end else if (stat.leaf) begin
          ctl.finish = 1'b1;
          nextState  = S_FIN;
        end else begin
          ctl.descend = 1'b1;
          nextState   = S_RD;
        end
      end
      S_CAS: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        nextState   = S_CAS_WAIT;
      end
      S_CAS_WAIT: if (memRespValid) begin
        if (memCasOk) begin
          if (stat.leaf) begin
            ctl.finish = 1'b1;
            nextState  = S_FIN;
          end else begin
            ctl.descend = 1'b1;
            nextState   = S_RD;
          end
        end else begin
          ctl.restart = stat.leaf;
          nextState   = S_RD;
        end
      end
      S_FIN: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/ptWalker.sv
module ptWalker
  import ptw_pkg::*;
#(
  parameter int PA_W      = 52,
  parameter int PHYS_BITS = 40,
  localparam int FRAME_W  = PA_W - 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [63:0]        reqVaddr,
  input  logic               reqStore,
  input  logic [FRAME_W-1:0] reqRootFrame,
  input  logic               reqNxEn,
  output logic               memReqValid,
  output logic               memReqWrite,
  output logic [PA_W-1:0]    memReqAddr,
  output logic [31:0]        memCmpData,
  output logic [31:0]        memWrData,
  input  logic               memRespValid,
  input  logic [63:0]        memRespData,
  input  logic               memCasOk,
  output logic               done,
  output logic               fault,
  output logic [1:0]         faultKind,
  output logic [PA_W-1:0]    paddr,
  output logic [1:0]         pageSize,
  output logic               permUser,
  output logic               permWrite,
  output logic               permExec
);
  walkCtl_t  ctl;
  walkStat_t stat;
  logic [2:0] perm;

  ptwControl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .stat(stat),
    .memRespValid(memRespValid), .memCasOk(memCasOk), .ctl(ctl),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .done(done)
  );

  ptwDatapath #(
    .VA_W(48), .LEVELS(4), .IDX_W(9), .PAGE_SHIFT(12),
    .PA_W(PA_W), .PHYS_BITS(PHYS_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stat(stat),
    .reqVaddr(reqVaddr), .reqStore(reqStore), .reqRootFrame(reqRootFrame),
    .reqNxEn(reqNxEn), .memRespData(memRespData), .memAddr(memReqAddr),
    .casCmp(memCmpData), .casNew(memWrData), .outFault(fault),
    .outKind(faultKind), .outPaddr(paddr), .outSize(pageSize), .outPerm(perm)
  );

  assign {permUser, permWrite, permExec} = perm;
endmodule

// File: rtl/ptWalker_chk.sv
module ptWalker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        done,
  input logic        fault,
  input logic [1:0]  faultKind,
  input logic [1:0]  pageSize,
  input logic        memReqValid,
  input logic        memReqWrite,
  input logic [31:0] memCmpData,
  input logic [31:0] memWrData
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R11
  single_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);
  // R8
  cas_sets_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |->
      (((memWrData & memCmpData) == memCmpData) && (memWrData != memCmpData)));
  // R7
  cas_accessed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> memWrData[5]);
  // R10
  size_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault) |-> (pageSize != 2'd3) && (faultKind == 2'd0));
  // R3
  fault_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault) |-> (faultKind != 2'd0));
endmodule

bind ptWalker ptWalker_chk u_chk (
  .clk(clk), .rstN(rstN), .done(done), .fault(fault), .faultKind(faultKind),
  .pageSize(pageSize), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
  .memCmpData(memCmpData), .memWrData(memWrData)
);

// File: tb/ptWalker_bench.sv
module ptWalker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] reqVaddr = '0;
  logic        reqStore = 1'b0;
  logic [39:0] reqRootFrame = 40'h1;
  logic        reqNxEn = 1'b1;
  logic        memReqValid, memReqWrite;
  logic [51:0] memReqAddr;
  logic [31:0] memCmpData, memWrData;
  logic        memRespValid = 1'b0;
  logic [63:0] memRespData = '0;
  logic        memCasOk = 1'b0;
  logic        done, fault, permUser, permWrite, permExec;
  logic [1:0]  faultKind, pageSize;
  logic [51:0] paddr;

  always #10 clk = ~clk;

  ptWalker u_ptWalker (.*);

  // memory model
  logic [63:0] mem [logic [51:0]];
  logic        pend = 1'b0, pendWr = 1'b0;
  logic [51:0] pendAddr = '0;
  logic [31:0] pendCmp = '0, pendNew = '0;
  int rdTotal = 0, casTotal = 0, doneTotal = 0;
  int failArm = 0, failUsed = 0;
  logic [31:0] injectBits = '0;
  logic [51:0] rdLog [64];

  function automatic logic [63:0] rdMem(logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  always @(posedge clk) begin
    memRespValid <= 1'b0;
    if (done) doneTotal++;
    if (pend) begin
      logic [63:0] cur;
      cur = rdMem(pendAddr);
      memRespValid <= 1'b1;
      memRespData  <= cur;
      if (pendWr) begin
        if (failArm != failUsed) begin
          failUsed++;
          mem[pendAddr] = cur | {32'h0, injectBits};
          memCasOk <= 1'b0;
        end else if (cur[31:0] == pendCmp) begin
          mem[pendAddr] = {cur[63:32], pendNew};
          memCasOk <= 1'b1;
        end else begin
          memCasOk <= 1'b0;
        end
      end
      pend <= 1'b0;
    end
    if (memReqValid) begin
      pend <= 1'b1; pendWr <= memReqWrite; pendAddr <= memReqAddr;
      pendCmp <= memCmpData; pendNew <= memWrData;
      if (memReqWrite) casTotal++;
      else begin rdLog[rdTotal % 64] = memReqAddr; rdTotal++; end
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic        rFault;
  logic [1:0]  rKind, rSize;
  logic [51:0] rPa;
  logic [2:0]  rPerm;
  int rdBase, casBase;

  task automatic walk(logic [63:0] va, logic st, logic nx);
    @(negedge clk);
    rdBase = rdTotal; casBase = casTotal;
    reqValid = 1'b1; reqVaddr = va; reqStore = st; reqNxEn = nx;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done) @(negedge clk);
    rFault = fault; rKind = faultKind; rSize = pageSize; rPa = paddr;
    rPerm = {permUser, permWrite, permExec};
  endtask

  typedef struct packed {
    logic [63:0] va; logic st; logic nx; logic [1:0] kind;
    logic [51:0] pa; logic [1:0] size; logic [2:0] perm;
  } vec_t;
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{64'h123,               1'b0, 1'b1, 2'd0, 52'habc123,   2'd0, 3'b111},
    '{64'h1456,              1'b1, 1'b1, 2'd0, 52'hdef456,   2'd0, 3'b101},
    '{64'h52345678,          1'b0, 1'b1, 2'd0, 52'h52345678, 2'd2, 3'b111},
    '{64'h80000000,          1'b0, 1'b1, 2'd2, 52'h0,        2'd0, 3'b000},
    '{64'hC0000000,          1'b0, 1'b1, 2'd2, 52'h0,        2'd0, 3'b000},
    '{64'h8000000000,        1'b0, 1'b1, 2'd1, 52'h0,        2'd0, 3'b000},
    '{64'h21abcd,            1'b0, 1'b1, 2'd0, 52'h61abcd,   2'd1, 3'b011},
    '{64'h400055,            1'b1, 1'b1, 2'd0, 52'h800055,   2'd1, 3'b111},
    '{64'h600000,            1'b0, 1'b1, 2'd1, 52'h0,        2'd0, 3'b000},
    '{64'h2000,              1'b0, 1'b1, 2'd1, 52'h0,        2'd0, 3'b000},
    '{64'h800010,            1'b0, 1'b1, 2'd0, 52'habc010,   2'd0, 3'b110},
    '{64'h800010,            1'b0, 1'b0, 2'd2, 52'h0,        2'd0, 3'b000},
    '{64'h0000800000000000,  1'b0, 1'b1, 2'd3, 52'h0,        2'd0, 3'b000},
    '{64'hFFFF800000000000,  1'b0, 1'b1, 2'd1, 52'h0,        2'd0, 3'b000},
    '{64'h10000000000,       1'b0, 1'b1, 2'd2, 52'h0,        2'd0, 3'b000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    mem[52'h1000] = 64'h2007;       mem[52'h1008] = 64'h0;
    mem[52'h1010] = 64'h2087;
    mem[52'h2000] = 64'h3027;       mem[52'h2008] = 64'h40000087;
    mem[52'h2010] = 64'h80002087;   mem[52'h2018] = (64'h1 << 45) | 64'h3007;
    mem[52'h3000] = 64'h4007;       mem[52'h3008] = 64'h600083;
    mem[52'h3010] = 64'h801087;     mem[52'h3020] = 64'h8000000000004007;
    mem[52'h4000] = 64'habc007;     mem[52'h4008] = 64'hdef005;

    repeat (3) @(negedge clk);
    chk("R12 done in reset", {63'h0, done}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 done after reset", {63'h0, done}, 64'h0);
    chk("R12 memReqValid after reset", {63'h0, memReqValid}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      walk(VECS[i].va, VECS[i].st, VECS[i].nx);
      chk($sformatf("R3/R4/R6 vec%0d faultKind", i), {62'h0, rKind}, {62'h0, VECS[i].kind});
      chk($sformatf("R10 vec%0d fault", i), {63'h0, rFault}, {63'h0, VECS[i].kind != 2'd0});
      if (VECS[i].kind == 2'd0) begin
        chk($sformatf("R10 vec%0d paddr", i), {12'h0, rPa}, {12'h0, VECS[i].pa});
        chk($sformatf("R5 vec%0d pageSize", i), {62'h0, rSize}, {62'h0, VECS[i].size});
        chk($sformatf("R9 vec%0d perm", i), {61'h0, rPerm}, {61'h0, VECS[i].perm});
      end
      if (VECS[i].kind == 2'd3)
        chk("R1 no memory access", 64'(rdTotal - rdBase + casTotal - casBase), 64'h0);
    end

    // R8: accessed on load, accessed+dirty on store; R7 pointer accessed
    chk("R8 load leaf A only", rdMem(52'h4000), 64'habc027);
    chk("R8 store leaf A and D", rdMem(52'h4008), 64'hdef065);
    chk("R7 top pointer accessed", rdMem(52'h1000), 64'h2027);
    chk("R8 2M store leaf A and D", rdMem(52'h3010), 64'h8010e7);

    // R2 entry addresses
    walk(64'h1456, 1'b0, 1'b1);
    chk("R2 first read at root", {12'h0, rdLog[rdBase % 64]}, 64'h1000);
    chk("R2 last read index", {12'h0, rdLog[(rdBase + 3) % 64]}, 64'h4008);
    chk("R8 no swap when bits set", 64'(casTotal - casBase), 64'h0);

    // R7 failed pointer swap re-reads only that entry
    mem[52'h1000] = 64'h2007; mem[52'h3000] = 64'h4027; mem[52'h4000] = 64'habc027;
    injectBits = 32'h20; failArm++;
    walk(64'h123, 1'b0, 1'b1);
    chk("R7 reads after pointer retry", 64'(rdTotal - rdBase), 64'd5);
    chk("R7 swaps after pointer retry", 64'(casTotal - casBase), 64'd1);
    chk("R7 re-read same entry", {12'h0, rdLog[(rdBase + 1) % 64]}, 64'h1000);
    chk("R7 result after retry", {12'h0, rPa}, 64'habc123);

    // R8 failed leaf swap restarts from the top table
    mem[52'h4000] = 64'habc007;
    injectBits = 32'h20; failArm++;
    walk(64'h123, 1'b1, 1'b1);
    chk("R8 reads after leaf restart", 64'(rdTotal - rdBase), 64'd8);
    chk("R8 swaps after leaf restart", 64'(casTotal - casBase), 64'd2);
    chk("R8 restart at root", {12'h0, rdLog[(rdBase + 4) % 64]}, 64'h1000);
    chk("R8 final leaf value", rdMem(52'h4000), 64'habc067);
    chk("R8 result after restart", {12'h0, rPa}, 64'habc123);

    // R11 request during a walk is ignored
    begin
      int d0;
      @(negedge clk);
      d0 = doneTotal;
      reqValid = 1'b1; reqVaddr = 64'h123; reqStore = 1'b0;
      @(negedge clk);
      reqValid = 1'b1; reqVaddr = 64'h0000800000000000;
      @(negedge clk);
      reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      while (!done) @(negedge clk);
      chk("R11 first walk wins", {62'h0, faultKind}, 64'h0);
      chk("R11 paddr of first walk", {12'h0, paddr}, 64'habc123);
      repeat (12) @(negedge clk);
      chk("R11 one done pulse", 64'(doneTotal - d0), 64'd1);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule